// File: doc/BRIEF.md
# Serial Programming Target Page Loader

This block is the device-side receiver for a four-byte serial programming protocol. A host drives a serial clock and a data line while holding the programming reset pin low. The block oversamples both lines with its own system clock. It assembles 32-bit frames, decodes them and turns them into requests on simple memory ports. Read data goes back to the host on the serial output line.

Flash writes use a page model. Each word of the page buffer is filled one byte at a time, and a page-write frame then asks the memory to commit the buffer. Every flash address has a sticky extended byte in front of it, set by a dedicated frame. Single EEPROM bytes are written directly. The memory reports a busy flag, and frames that complete while it is raised have no effect.

Before any frame has effect, the host must send a valid enable frame. Its second byte is echoed during the third byte so the host can confirm bit alignment. Raising the reset pin drops the enabled state and discards any partial frame, so a desynchronised host recovers by pulsing reset and sending a new enable frame.

Top module: `spt_target`

## Requirements
- R1: The design samples `mosi` on rising edges of `sck`, sending frame bit 31 first. `miso` changes only after a falling edge of `sck` or while `progRst` is high.
- R2: After reset `miso` is 0 and no request is raised. Until a frame 0xAC, 0x53, x, x has completed, every other frame raises no request. A frame 0xAC with any other second byte does not enable the design.
- R3: In any frame whose first byte is 0xAC, `miso` shifts out the received second byte, MSB first, while the host sends the third byte.
- R4: Frame 0x40 (low byte) or 0x48 (high byte) writes the fourth byte into the page-buffer word chosen by bits 6..0 of the third byte. The buffer reads 0xFFFF after reset and is visible on `pgRdWord` at index `pgRdIdx`.
- R5: A high-byte load takes effect only if a low-byte load to the same word came before it, with no high-byte load or page write in between. Otherwise it is ignored.
- R6: Frame 0x4C pulses `pageCommitReq`. `pageCommitAddr` is {extended byte, second byte, third byte with bits 6..0 cleared}. The frame also clears every pending low-byte mark.
- R7: Frame 0x4D stores its fourth byte as the extended address byte. This byte is 0 after reset, is kept across `progRst` pulses and other frames, and forms bits 23..16 of every flash read and commit address.
- R8: Frame 0xC0 pulses `eeWrReq` with `eeAddr` = {second, third byte} and `eeData` = fourth byte. The memory erases the location and then writes it.
- R9: Frames 0x20 (flash low byte), 0x28 (flash high byte) and 0xA0 (EEPROM) pulse `rdReq` once the third byte has arrived. `rdSel` is 0, 1 or 2 respectively. `rdAddr` is {extended byte, second, third byte} for flash and {0x00, second, third byte} for EEPROM. `rdData` is shifted out on `miso` during the fourth byte, MSB first.
- R10: While `progRst` is high, the bit count is held at zero and the enabled state is cleared. After it falls, the design needs a new enable frame.
- R11: A write, load, extended-address or commit frame that completes while `memBusy` is high is ignored. A read whose third byte arrives while `memBusy` is high raises no `rdReq` and returns 0x00.
- R12: `rdReq`, `pageCommitReq` and `eeWrReq` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| progRst | input | 1 | Programming reset pin, low selects programming |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| memBusy | input | 1 | Memory operation in progress |
| rdReq | output | 1 | Read request pulse |
| rdSel | output | 2 | Read target: 0 flash low, 1 flash high, 2 EEPROM |
| rdAddr | output | 24 | Read address |
| rdData | input | 8 | Read data, valid in the same cycle as `rdReq` |
| pageCommitReq | output | 1 | Page commit pulse |
| pageCommitAddr | output | 24 | Page word address for commit |
| pgRdIdx | input | PAGE_IDX_W | Page buffer read index |
| pgRdWord | output | 16 | Page buffer word at `pgRdIdx` |
| eeWrReq | output | 1 | EEPROM write pulse |
| eeAddr | output | 16 | EEPROM write address |
| eeData | output | 8 | EEPROM write data |

## Verification
The assertions check several properties on every cycle:
- the request pulses are exclusive and last one cycle;
- no request appears unless the enabled state is held and the memory is idle;
- `miso` changes only after a detected falling edge or a reset-pin clear;
- the enabled state drops whenever the reset pin is high.

Behaviours that depend on frame content can only be shown by the bench's scenarios:
- the echo of the sync byte and the returned read bytes;
- the page-buffer contents and the low-before-high rule;
- the sticky extended byte in later addresses;
- recovery after a partial frame.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam logic [7:0] OP_ENABLE = 8'hAC;
  localparam logic [7:0] SYNC_BYTE = 8'h53;
  localparam logic [7:0] OP_LD_LO  = 8'h40;
  localparam logic [7:0] OP_LD_HI  = 8'h48;
  localparam logic [7:0] OP_COMMIT = 8'h4C;
  localparam logic [7:0] OP_EXT    = 8'h4D;
  localparam logic [7:0] OP_EE_WR  = 8'hC0;
  localparam logic [7:0] OP_RD_LO  = 8'h20;
  localparam logic [7:0] OP_RD_HI  = 8'h28;
  localparam logic [7:0] OP_RD_EE  = 8'hA0;

  typedef enum logic [1:0] {
    RD_FLASH_LO = 2'd0,
    RD_FLASH_HI = 2'd1,
    RD_EEPROM   = 2'd2
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic txClear;
    logic loadEcho;
    logic loadRead;
    logic readOk;
    logic wrLo;
    logic wrHi;
    logic commit;
    logic setExt;
    logic eeWrite;
  } strobe_t;
endpackage

// File: rtl/spt_ctrl.sv
module spt_ctrl
  import spt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckIn,
  input  logic        mosiIn,
  input  logic        progRstIn,
  input  logic        memBusy,
  input  logic [23:0] frameHi,   // rxNext[31:8]
  output logic        mosiS,
  output logic        progRstS,
  output logic        enabled,
  output strobe_t     strb
);
  localparam int CNT_W = 5;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(31);
  localparam logic [CNT_W-1:0] ECHO_BIT  = CNT_W'(15);
  localparam logic [CNT_W-1:0] READ_BIT  = CNT_W'(23);

  // stage bits: {sck, mosi, progRst}
  logic [2:0] syncSh [SYNC_STAGES];
  logic       sckS, sckQ, rise, fall;
  logic [CNT_W-1:0] bitCnt;
  logic       frameEnd, execOk, isRead;
  logic [7:0] endOp, endB1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncSh[s] <= 3'b001;
    end else begin
      syncSh[0] <= {sckIn, mosiIn, progRstIn};
      for (int s = 1; s < SYNC_STAGES; s++) syncSh[s] <= syncSh[s-1];
    end
  end

  assign sckS     = syncSh[SYNC_STAGES-1][2];
  assign mosiS    = syncSh[SYNC_STAGES-1][1];
  assign progRstS = syncSh[SYNC_STAGES-1][0];
  assign rise     = sckS & ~sckQ & ~progRstS;
  assign fall     = ~sckS & sckQ & ~progRstS;
  assign endOp    = frameHi[23:16];
  assign endB1    = frameHi[15:8];
  assign frameEnd = rise && (bitCnt == LAST_BIT);
  assign execOk   = frameEnd && enabled && !memBusy;
  assign isRead   = (frameHi[15:8] == OP_RD_LO) || (frameHi[15:8] == OP_RD_HI) ||
                    (frameHi[15:8] == OP_RD_EE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ    <= 1'b0;
      bitCnt  <= '0;
      enabled <= 1'b0;
    end else begin
      sckQ <= sckS;
      if (progRstS) begin
        bitCnt  <= '0;
        enabled <= 1'b0;
      end else if (rise) begin
        bitCnt <= bitCnt + CNT_W'(1);
        if (frameEnd && !enabled && endOp == OP_ENABLE && endB1 == SYNC_BYTE)
          enabled <= 1'b1;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.shiftIn  = rise;
    strb.shiftOut = fall;
    strb.txClear  = progRstS;
    strb.loadEcho = rise && (bitCnt == ECHO_BIT) && (frameHi[7:0] == OP_ENABLE);
    strb.loadRead = rise && (bitCnt == READ_BIT);
    strb.readOk   = enabled && !memBusy && isRead;
    if (execOk) begin
      case (endOp)
        OP_LD_LO:  strb.wrLo    = 1'b1;
        OP_LD_HI:  strb.wrHi    = 1'b1;
        OP_COMMIT: strb.commit  = 1'b1;
        OP_EXT:    strb.setExt  = 1'b1;
        OP_EE_WR:  strb.eeWrite = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/spt_datapath.sv
module spt_datapath
  import spt_pkg::*;
#(
  parameter int PAGE_IDX_W = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic                  mosiS,
  input  logic [7:0]            rdData,
  input  logic [PAGE_IDX_W-1:0] pgRdIdx,
  output logic [31:0]           rxNext,
  output logic                  miso,
  output logic                  rdReq,
  output rdSel_e                rdSel,
  output logic [23:0]           rdAddr,
  output logic                  pageCommitReq,
  output logic [23:0]           pageCommitAddr,
  output logic                  eeWrReq,
  output logic [15:0]           eeAddr,
  output logic [7:0]            eeData,
  output logic [15:0]           pgRdWord
);
  localparam int PAGE_WORDS = 1 << PAGE_IDX_W;
  localparam logic [15:0] WORD_MASK = 16'(PAGE_WORDS - 1);

  logic [31:0] rxReg;
  logic [7:0]  txReg, extAddr;
  logic [15:0] pageBuf [PAGE_WORDS];
  logic        loDone  [PAGE_WORDS];
  logic [PAGE_IDX_W-1:0] wIdx;
  logic [7:0]  wData;

  assign rxNext = {rxReg[30:0], mosiS};
  assign wIdx   = rxNext[8 +: PAGE_IDX_W];
  assign wData  = rxNext[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxReg <= '0;
    else if (strb.shiftIn) rxReg <= rxNext;
  end

  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
    logic hit;
    assign hit = (wIdx == PAGE_IDX_W'(w));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[w] <= 16'hFFFF;
        loDone[w]  <= 1'b0;
      end else if (strb.commit) begin
        loDone[w] <= 1'b0;
      end else if (strb.wrLo && hit) begin
        pageBuf[w][7:0] <= wData;
        loDone[w]       <= 1'b1;
      end else if (strb.wrHi && hit) begin
        if (loDone[w]) pageBuf[w][15:8] <= wData;
        loDone[w] <= 1'b0;
      end
    end
  end

  assign pgRdWord = pageBuf[pgRdIdx];

  // read port: frame holds op/b1/b2 in rxNext[23:0] at the read point
  always_comb begin
    case (rxNext[23:16])
      OP_RD_HI: rdSel = RD_FLASH_HI;
      OP_RD_EE: rdSel = RD_EEPROM;
      default:  rdSel = RD_FLASH_LO;
    endcase
    rdAddr = (rdSel == RD_EEPROM) ? {8'h00, rxNext[15:0]} : {extAddr, rxNext[15:0]};
  end
  assign rdReq = strb.loadRead & strb.readOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extAddr        <= '0;
      pageCommitReq  <= 1'b0;
      pageCommitAddr <= '0;
      eeWrReq        <= 1'b0;
      eeAddr         <= '0;
      eeData         <= '0;
    end else begin
      pageCommitReq <= strb.commit;
      eeWrReq       <= strb.eeWrite;
      if (strb.setExt) extAddr <= wData;
      if (strb.commit) pageCommitAddr <= {extAddr, rxNext[23:8] & ~WORD_MASK};
      if (strb.eeWrite) begin
        eeAddr <= rxNext[23:8];
        eeData <= wData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
      miso  <= 1'b0;
    end else if (strb.txClear) begin
      txReg <= '0;
      miso  <= 1'b0;
    end else if (strb.loadEcho) begin
      txReg <= rxNext[7:0];
    end else if (strb.loadRead) begin
      txReg <= rdReq ? rdData : 8'h00;
    end else if (strb.shiftOut) begin
      miso  <= txReg[7];
      txReg <= {txReg[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spt_target.sv
module spt_target
  import spt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_IDX_W  = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  progRst,
  input  logic                  sck,
  input  logic                  mosi,
  output logic                  miso,
  input  logic                  memBusy,
  output logic                  rdReq,
  output logic [1:0]            rdSel,
  output logic [23:0]           rdAddr,
  input  logic [7:0]            rdData,
  output logic                  pageCommitReq,
  output logic [23:0]           pageCommitAddr,
  input  logic [PAGE_IDX_W-1:0] pgRdIdx,
  output logic [15:0]           pgRdWord,
  output logic                  eeWrReq,
  output logic [15:0]           eeAddr,
  output logic [7:0]            eeData
);
  strobe_t     strb;
  logic        mosiS, progRstS, enabled;
  logic [31:0] rxNext;
  rdSel_e      rdSelE;

  spt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sck), .mosiIn(mosi), .progRstIn(progRst),
    .memBusy(memBusy), .frameHi(rxNext[31:8]), .mosiS(mosiS),
    .progRstS(progRstS), .enabled(enabled), .strb(strb)
  );

  spt_datapath #(.PAGE_IDX_W(PAGE_IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(mosiS), .rdData(rdData),
    .pgRdIdx(pgRdIdx), .rxNext(rxNext), .miso(miso), .rdReq(rdReq),
    .rdSel(rdSelE), .rdAddr(rdAddr), .pageCommitReq(pageCommitReq),
    .pageCommitAddr(pageCommitAddr), .eeWrReq(eeWrReq), .eeAddr(eeAddr),
    .eeData(eeData), .pgRdWord(pgRdWord)
  );

  assign rdSel = rdSelE;
endmodule

// File: rtl/spt_target_chk.sv
module spt_target_chk (
  input logic clk,
  input logic rstN,
  input logic progRstS,
  input logic enabled,
  input logic misoShift,
  input logic misoClear,
  input logic miso,
  input logic memBusy,
  input logic rdReq,
  input logic pageCommitReq,
  input logic eeWrReq
);
  a_r12_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdReq, pageCommitReq, eeWrReq}));
  a_r12_commit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pageCommitReq |=> !pageCommitReq);
  a_r12_ee_pulse: assert property (@(posedge clk) disable iff (!rstN)
    eeWrReq |=> !eeWrReq);
  a_r2_read_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> enabled);
  a_r2_write_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (pageCommitReq || eeWrReq) |-> $past(enabled));
  a_r11_read_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !memBusy);
  a_r11_write_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    (pageCommitReq || eeWrReq) |-> $past(!memBusy));
  a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (miso != $past(miso)) |-> $past(misoShift || misoClear));
  a_r10_reset_drops: assert property (@(posedge clk) disable iff (!rstN)
    progRstS |=> !enabled);
endmodule

bind spt_target spt_target_chk u_chk (
  .clk(clk), .rstN(rstN), .progRstS(progRstS), .enabled(enabled),
  .misoShift(strb.shiftOut), .misoClear(strb.txClear), .miso(miso),
  .memBusy(memBusy), .rdReq(rdReq), .pageCommitReq(pageCommitReq),
  .eeWrReq(eeWrReq)
);

// File: tb/spt_target_bench.sv
module spt_target_bench;
  localparam int HALF = 8;
  localparam int NV = 11;

  logic clk = 1'b0, rstN = 1'b0, progRst = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic memBusy = 1'b0;
  logic [6:0] pgRdIdx = '0;
  logic miso, rdReq, pageCommitReq, eeWrReq;
  logic [1:0] rdSel;
  logic [23:0] rdAddr, pageCommitAddr;
  logic [7:0] rdData, eeData;
  logic [15:0] pgRdWord, eeAddr;

  int nErr = 0, nChecks = 0;
  int rdCnt = 0, cmCnt = 0, eeCnt = 0;
  logic [23:0] lastRdAddr = '0, lastCmAddr = '0;
  logic [15:0] lastEeAddr = '0;
  logic [7:0]  lastEeData = '0;
  logic [31:0] cap;

  always #2 clk = ~clk;

  // memory model for reads
  assign rdData = rdAddr[7:0] ^ rdAddr[23:16] ^ (rdSel == 2'd1 ? 8'h5A : 8'h00) ^
                  (rdSel == 2'd2 ? 8'hC3 : 8'h00);

  spt_target u_spt_target (
    .clk(clk), .rstN(rstN), .progRst(progRst), .sck(sck), .mosi(mosi), .miso(miso),
    .memBusy(memBusy), .rdReq(rdReq), .rdSel(rdSel), .rdAddr(rdAddr), .rdData(rdData),
    .pageCommitReq(pageCommitReq), .pageCommitAddr(pageCommitAddr), .pgRdIdx(pgRdIdx),
    .pgRdWord(pgRdWord), .eeWrReq(eeWrReq), .eeAddr(eeAddr), .eeData(eeData)
  );

  always @(negedge clk) begin
    if (rdReq) begin rdCnt++; lastRdAddr = rdAddr; end
    if (pageCommitReq) begin cmCnt++; lastCmAddr = pageCommitAddr; end
    if (eeWrReq) begin eeCnt++; lastEeAddr = eeAddr; lastEeData = eeData; end
  end

  // frame, kind (0 none, 1 commit, 2 eeprom write, 3 read), address, data/read byte
  localparam logic [65:0] VEC [NV] = '{
    {32'h4D000001, 2'd0, 24'h000000, 8'h00},
    {32'h400005AA, 2'd0, 24'h000000, 8'h00},
    {32'h480005BB, 2'd0, 24'h000000, 8'h00},
    {32'h480006CC, 2'd0, 24'h000000, 8'h00},
    {32'h4C128000, 2'd1, 24'h011280, 8'h00},
    {32'hC001235E, 2'd2, 24'h000123, 8'h5E},
    {32'h20345600, 2'd3, 24'h013456, 8'h57},
    {32'h28345700, 2'd3, 24'h013457, 8'h0C},
    {32'hA0001000, 2'd3, 24'h000010, 8'hD3},
    {32'h4D000000, 2'd0, 24'h000000, 8'h00},
    {32'h20002200, 2'd3, 24'h000022, 8'h22}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [31:0] f, input int n, output logic [31:0] c);
    c = '0;
    for (int i = 31; i >= 32 - n; i--) begin
      mosi = f[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      c[i] = miso;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [31:0] f, output logic [31:0] c);
    sendBits(f, 32, c);
  endtask

  task automatic pulseProgRst();
    progRst = 1'b1;
    repeat (20) @(negedge clk);
    progRst = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int r0, c0, e0;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // reset state
    chk(miso == 1'b0, "R2 reset miso", 32'(miso), 0);
    chk(rdCnt + cmCnt + eeCnt == 0, "R2 reset no requests", 32'(rdCnt + cmCnt + eeCnt), 0);
    chk(pgRdWord == 16'hFFFF, "R4 reset buffer", 32'(pgRdWord), 32'hFFFF);
    progRst = 1'b0;
    repeat (10) @(negedge clk);

    // commands before enable are ignored
    sendFrame(32'hC0000177, cap);
    chk(eeCnt == 0, "R2 write before enable", 32'(eeCnt), 0);
    sendFrame(32'h20001100, cap);
    chk(rdCnt == 0 && cap == 0, "R2 read before enable", cap, 0);

    // enable with echo
    sendFrame(32'hAC530000, cap);
    chk(cap[15:8] == 8'h53, "R3 sync echo", 32'(cap[15:8]), 32'h53);
    chk(cap[7:0] == 8'h00 && cap[31:16] == 0, "R1 miso idle outside echo", cap, 32'h00005300);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [31:0] f;
      logic [1:0] kind;
      logic [23:0] ea;
      logic [7:0] ed;
      {f, kind, ea, ed} = VEC[k];
      r0 = rdCnt; c0 = cmCnt; e0 = eeCnt;
      sendFrame(f, cap);
      case (kind)
        2'd0: chk(rdCnt == r0 && cmCnt == c0 && eeCnt == e0,
                  "R4 R5 R7 no request on load/ext", f, 0);
        2'd1: begin
          chk(cmCnt == c0 + 1, "R12 single commit pulse", 32'(cmCnt - c0), 1);
          chk(lastCmAddr == ea, "R6 R7 commit address", 32'(lastCmAddr), 32'(ea));
        end
        2'd2: begin
          chk(eeCnt == e0 + 1, "R8 single write pulse", 32'(eeCnt - e0), 1);
          chk(lastEeAddr == ea[15:0] && lastEeData == ed, "R8 write addr/data",
              {lastEeAddr, 8'h00, lastEeData}, {ea[15:0], 8'h00, ed});
        end
        default: begin
          chk(rdCnt == r0 + 1, "R9 single read pulse", 32'(rdCnt - r0), 1);
          chk(lastRdAddr == ea, "R7 R9 read address", 32'(lastRdAddr), 32'(ea));
          chk(cap[7:0] == ed, "R9 read byte on miso", 32'(cap[7:0]), 32'(ed));
        end
      endcase
    end

    // page buffer contents
    pgRdIdx = 7'd5; @(negedge clk);
    chk(pgRdWord == 16'hBBAA, "R4 word low then high", 32'(pgRdWord), 32'hBBAA);
    pgRdIdx = 7'd6; @(negedge clk);
    chk(pgRdWord == 16'hFFFF, "R5 high without low ignored", 32'(pgRdWord), 32'hFFFF);
    sendFrame(32'h48000511, cap);
    pgRdIdx = 7'd5; @(negedge clk);
    chk(pgRdWord == 16'hBBAA, "R5 R6 commit clears low marks", 32'(pgRdWord), 32'hBBAA);

    // busy
    memBusy = 1'b1;
    e0 = eeCnt; r0 = rdCnt;
    sendFrame(32'hC0000942, cap);
    chk(eeCnt == e0, "R11 write while busy", 32'(eeCnt - e0), 0);
    sendFrame(32'h20001100, cap);
    chk(rdCnt == r0 && cap[7:0] == 0, "R11 read while busy", 32'(cap[7:0]), 0);
    sendFrame(32'h40000799, cap);
    memBusy = 1'b0;
    pgRdIdx = 7'd7; @(negedge clk);
    chk(pgRdWord == 16'hFFFF, "R11 load while busy", 32'(pgRdWord), 32'hFFFF);

    // reset pin drops enable
    pulseProgRst();
    e0 = eeCnt;
    sendFrame(32'hC0000155, cap);
    chk(eeCnt == e0, "R10 not enabled after reset pin", 32'(eeCnt - e0), 0);
    // wrong sync byte still echoed but does not enable
    sendFrame(32'hAC110000, cap);
    chk(cap[15:8] == 8'h11, "R3 echo of any second byte", 32'(cap[15:8]), 32'h11);
    sendFrame(32'hC0000155, cap);
    chk(eeCnt == e0, "R2 bad sync does not enable", 32'(eeCnt - e0), 0);
    // partial frame then recovery
    sendBits(32'hAC530000, 12, cap);
    pulseProgRst();
    sendFrame(32'hAC530000, cap);
    chk(cap[15:8] == 8'h53, "R10 realigned echo", 32'(cap[15:8]), 32'h53);
    sendFrame(32'hC00234A5, cap);
    chk(eeCnt == e0 + 1 && lastEeAddr == 16'h0234 && lastEeData == 8'hA5,
        "R10 R8 write after recovery", {lastEeAddr, lastEeData, 8'(eeCnt - e0)},
        {16'h0234, 8'hA5, 8'h01});

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule